// File: doc/BRIEF.md
# Request/Acknowledge Word Crossing

This block carries one multi-bit word at a time from a sending clock domain to an unrelated receiving clock domain. The word travels on a bus that is never synchronized. Only two control lines cross the boundary. A request line goes from sender to receiver, and an acknowledge line comes back. Each of these passes through its own flop chain clocked by the domain that reads it. The whole bus therefore has one synchronization point, and no per-bit skew can mix old and new bits.

On the sending side, a word is offered with a valid strobe. It is taken only while the block reports idle, and the block then reports busy until the exchange has fully returned to rest. The sender registers the word and waits one cycle before raising the request. It drops the request once it sees the acknowledge, and it accepts nothing new until it sees the acknowledge fall.

The receiver captures the bus when it sees the request. It raises the acknowledge in the same edge that presents the word and a one-cycle valid strobe. It lowers the acknowledge once it sees the request withdrawn. Each domain has its own synchronous active-high reset.

Top module: `hs_bus_sync`

## Requirements
- R1: While reset is held, and in the first cycle after it, `src_busy` and `dst_valid` are 0, and both the request and the acknowledge lines are 0.
- R2: A word is accepted at a `src_clk` edge where `src_valid` is 1 and `src_busy` is 0, and `src_busy` is 1 from the next cycle on.
- R3: Each accepted word appears on `dst_data`, with all `DATA_W` bits unchanged, in the order the words were accepted.
- R4: `dst_valid` is high for exactly one `dst_clk` cycle per delivered word, and is never high in two consecutive cycles.
- R5: `src_valid` is ignored while `src_busy` is 1. Such a word is never delivered, and `src_busy` stays 1.
- R6: The request rises only when the synchronized acknowledge is low, and only one cycle after the word was registered onto the bus.
- R7: The data bus holds its value in every cycle of a transfer after the cycle in which the word was loaded, until `src_busy` returns to 0.
- R8: The acknowledge rises only together with a capture (`dst_valid` high), and falls only after the synchronized request was seen low.
- R9: `src_busy` returns to 0 only after the synchronized acknowledge is seen low, so a new request never overlaps an acknowledge that is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Sending domain clock |
| src_rst | input | 1 | Sending domain synchronous reset, active high |
| src_valid | input | 1 | Offers `src_data` for transfer |
| src_data | input | DATA_W | Word to transfer |
| src_busy | output | 1 | High from acceptance until the handshake is back at rest |
| dst_clk | input | 1 | Receiving domain clock |
| dst_rst | input | 1 | Receiving domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle strobe marking a new word on `dst_data` |
| dst_data | output | DATA_W | Last captured word |

## Verification
The bench builds the block with `DATA_W` = 12 and `SYNC_STAGES` = 3.

A 12-bit bus makes all-zero, all-one, checkerboard and walking-bit words cheap to send. Any bit captured from the wrong word then shows up in the scoreboard compare. Three synchronizer stages stretch each handshake phase, which gives a longer window in which ignored offers on `src_valid` can be driven.

The two clocks run at unrelated periods, so the phase of the request and acknowledge edges drifts from one transfer to the next.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    TX_IDLE     = 2'd0,
    TX_LOAD     = 2'd1,
    TX_WAIT_ACK = 2'd2,
    TX_WAIT_REL = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_HOLD = 1'b1
  } rx_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];

  initial begin
    a_stage_count : assert (STAGES >= 2) else $error("hs_sync needs two or more stages");
  end
endmodule

// File: rtl/hs_sender.sv
module hs_sender
  import hs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              req,
  output logic [DATA_W-1:0] bus,
  input  logic              ack_async
);
  tx_state_e state;
  logic      ack_s;

  hs_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_async),
    .q   (ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      busy  <= 1'b0;
      req   <= 1'b0;
      bus   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (in_valid) begin
            bus   <= in_data;
            busy  <= 1'b1;
            state <= TX_LOAD;
          end
        end
        TX_LOAD: begin
          if (!ack_s) begin
            req   <= 1'b1;
            state <= TX_WAIT_ACK;
          end
        end
        TX_WAIT_ACK: begin
          if (ack_s) begin
            req   <= 1'b0;
            state <= TX_WAIT_REL;
          end
        end
        TX_WAIT_REL: begin
          if (!ack_s) begin
            busy  <= 1'b0;
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  a_r2_accept_sets_busy : assert property (@(posedge clk) disable iff (rst)
    in_valid && !busy |=> busy);

  a_r5_busy_holds_on_offer : assert property (@(posedge clk) disable iff (rst)
    in_valid && busy && req |=> busy);

  a_r6_req_after_ack_low : assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(ack_s) && $past(busy));

  a_r7_bus_stable : assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(bus));

  a_r9_idle_after_release : assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(ack_s) && !req);
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_async,
  input  logic [DATA_W-1:0] bus,
  output logic              ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  rx_state_e state;
  logic      req_s;

  hs_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      ack       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (req_s) begin
            out_data  <= bus;
            out_valid <= 1'b1;
            ack       <= 1'b1;
            state     <= RX_HOLD;
          end
        end
        RX_HOLD: begin
          if (!req_s) begin
            ack   <= 1'b0;
            state <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  a_r4_single_pulse : assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r8_ack_with_capture : assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> out_valid && $past(req_s));

  a_r8_ack_drop_after_req_low : assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> !$past(req_s));
endmodule

// File: rtl/hs_bus_sync.sv
module hs_bus_sync #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_busy,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_line;
  logic              ack_line;
  logic [DATA_W-1:0] word_bus;

  hs_sender #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_tx (
    .clk       (src_clk),
    .rst       (src_rst),
    .in_valid  (src_valid),
    .in_data   (src_data),
    .busy      (src_busy),
    .req       (req_line),
    .bus       (word_bus),
    .ack_async (ack_line)
  );

  hs_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk       (dst_clk),
    .rst       (dst_rst),
    .req_async (req_line),
    .bus       (word_bus),
    .ack       (ack_line),
    .out_valid (dst_valid),
    .out_data  (dst_data)
  );

  a_r1_src_reset : assert property (@(posedge src_clk)
    $past(src_rst) |-> !src_busy && !req_line);

  a_r1_dst_reset : assert property (@(posedge dst_clk)
    $past(dst_rst) |-> !dst_valid && !ack_line);
endmodule

// File: tb/test_hs_bus_sync.sv
module test_hs_bus_sync;
  localparam int DW = 12;
  localparam int NS = 3;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst = 1'b1;
  logic          dst_rst = 1'b1;
  logic          src_valid = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_busy;
  logic          dst_valid;
  logic [DW-1:0] dst_data;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  bit finished = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #2 src_clk = ~src_clk;   // 250 MHz
  always #3.5 dst_clk = ~dst_clk;

  hs_bus_sync #(.DATA_W(DW), .SYNC_STAGES(NS)) i_hs_bus_sync (
    .src_clk   (src_clk),
    .src_rst   (src_rst),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_busy  (src_busy),
    .dst_clk   (dst_clk),
    .dst_rst   (dst_rst),
    .dst_valid (dst_valid),
    .dst_data  (dst_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pop expected words as they arrive (R3), one-cycle strobe (R4)
  bit prev_valid = 1'b0;
  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      if (dst_valid) begin
        got++;
        check(!prev_valid, "R4", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", int'(dst_data), -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          // a bus change while the request is up would break this (R7)
          check(dst_data == e, "R3", int'(dst_data), int'(e));
        end
      end
      prev_valid = dst_valid;
    end
  end

  // Driver: push to scoreboard, then offer junk while busy (R5)
  task automatic send(input logic [DW-1:0] d);
    @(negedge src_clk);
    while (src_busy) @(negedge src_clk);
    src_valid = 1'b1;
    src_data  = d;
    exp_q.push_back(d);
    sent++;
    @(negedge src_clk);
    check(src_busy == 1'b1, "R2", int'(src_busy), 1);
    src_data = ~d;
    for (int k = 0; k < 3; k++) begin
      @(negedge src_clk);
      check(src_busy == 1'b1, "R5", int'(src_busy), 1);
    end
    src_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 30000; c++) @(posedge src_clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] lfsr;
    for (int c = 0; c < 4; c++) begin
      @(negedge src_clk);
      check(!src_busy, "R1", int'(src_busy), 0);
    end
    @(negedge dst_clk);
    check(!dst_valid, "R1", int'(dst_valid), 0);
    @(negedge src_clk); src_rst = 1'b0;
    @(negedge dst_clk); dst_rst = 1'b0;
    @(negedge src_clk);
    check(!src_busy, "R1", int'(src_busy), 0);

    send('0);
    send('1);
    send(12'hAAA);
    send(12'h555);
    for (int b = 0; b < DW; b++) send(DW'(1) << b);
    lfsr = 12'h9C3;
    for (int n = 0; n < 10; n++) begin
      lfsr = {lfsr[DW-2:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      send(lfsr);
    end

    for (int c = 0; c < 2000 && (exp_q.size() != 0 || src_busy); c++) @(negedge src_clk);
    for (int c = 0; c < 40; c++) @(negedge dst_clk);
    // exactly one capture per accepted word; no junk delivered (R5, R8)
    check(got == sent, "R8", got, sent);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    // handshake back at rest only after acknowledge low (R6, R9)
    check(!src_busy, "R9", int'(src_busy), 0);
    finish_run();
  end
endmodule